// File: doc/BRIEF.md
# Stream Frame and Packet Debug Counters

This block is a passive observer placed beside one or more sensor stream inputs and their packet transmit paths. It never drives the stream. For each sensor interface it keeps three free-running counters. The first counts the cycles on which the stream's valid is high. The second counts frame starts and serves as a frame sequence number. The third counts transmitted packets and serves as a packet sequence number. Bring-up software reads the counters to find where traffic stops. A valid count that does not move points at the stream source. Valid activity with no frame starts points at a missing last marker or a stalled ready. No packet count points at the transmit setup.

A frame start is the first completed handshake (valid and ready both high) after a handshake that carried the last marker. Out of reset the tracker is armed, so the very first handshake counts as a frame start. The transmitter supplies a one-cycle pulse for each packet it sends.

The counters are read through a simple read port with one cycle of latency. Each interface has its own register window, and the offset within the window selects the counter.

Top module: `stream_dbg_counters`

## Requirements
- R1: The valid counter of an interface increments by one on every clock cycle on which its `sif_tvalid` bit is high, whether its `sif_tready` bit is high or low.
- R2: A frame start is the first cycle with `sif_tvalid` and `sif_tready` both high following a handshake that had `sif_tlast` high. Right after reset the tracker is armed, so the first handshake is a frame start. The frame counter increments once per frame start.
- R3: A `sif_tlast` high on a cycle without a completed handshake (valid low, or ready low) neither arms nor disarms the tracker.
- R4: A frame-start handshake that itself carries `sif_tlast` keeps the tracker armed, so back-to-back single-beat frames each count.
- R5: The packet counter of an interface increments by one on every cycle on which its `pkt_sent` bit is high.
- R6: `rd_addr[ADDR_W-1:8]` selects the interface window, with a stride of 0x100. Within a window, offset 0x80 reads the valid counter, 0x84 reads the frame counter and 0x88 reads the packet counter. Any other offset, or a window index of NUM_IF or above, reads 0.
- R7: A read issued with `rd_en` high returns, on `rd_data` one cycle later, the counter value held in the cycle of the request (before that cycle's increment). `rd_data` holds its value while `rd_en` is low.
- R8: Counters are CNT_W bits wide (32 by default) and wrap to zero after 2^CNT_W increments.
- R9: Reset clears all counters and `rd_data` to 0, and re-arms the frame-start tracker.
- R10: The counters of each interface respond only to that interface's own input bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sif_tvalid | input | NUM_IF | Stream valid, one bit per interface |
| sif_tready | input | NUM_IF | Stream ready, one bit per interface |
| sif_tlast | input | NUM_IF | Stream last marker, one bit per interface |
| pkt_sent | input | NUM_IF | One-cycle packet-sent pulse, one bit per interface |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read result, valid one cycle after the request |

## Verification
The bench drives last markers while ready is low, and drives ready without valid. A design that arms on the raw last bit would count false frame starts there. It sends runs of single-beat frames; a tracker that disarms on every frame start would count only the first of them. It reads counters in the same cycle they increment, which catches a read path that samples a cycle late or forwards the new value. A narrow-counter instance runs past 2^8 valid cycles, so a counter that saturates or misses the wrap shows up. Reads to unused offsets and to out-of-range windows must return zero.

// File: rtl/stream_dbg_pkg.sv
package stream_dbg_pkg;
    localparam int RD_W      = 32;
    localparam int WIN_SHIFT = 8;
    localparam logic [7:0] OFF_VALID = 8'h80;
    localparam logic [7:0] OFF_FRAME = 8'h84;
    localparam logic [7:0] OFF_PKT   = 8'h88;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_VALID = 2'd1,
        SEL_FRAME = 2'd2,
        SEL_PKT   = 2'd3
    } cnt_sel_e;
endpackage

// File: rtl/sdc_counter.sv
module sdc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R8: one step per increment, wrapping modulo 2^W
    a_r8_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt_o == $past(cnt_o) + W'(1)));
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_o));
endmodule

// File: rtl/sdc_sof_tracker.sv
module sdc_sof_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic tvalid,
    input  logic tready,
    input  logic tlast,
    output logic sof_o
);
    typedef struct packed {
        logic armed;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic       hs;

    assign hs = tvalid & tready;

    always_comb begin
        st_d = st_q;
        if (hs) begin
            st_d.armed = tlast;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sof_o = hs & st_q.armed;

    // R3: the armed state only moves on a completed handshake
    a_r3_no_arm_without_hs: assert property (@(posedge clk) disable iff (!rst_n)
        !(tvalid && tready) |=> $stable(st_q.armed));
    // R2: a frame start without last disarms the tracker
    a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_o && !tlast) |=> !sof_o);
    // R4: a handshake with last arms the tracker for the next one
    a_r4_last_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && tready && tlast) |=> st_q.armed);
endmodule

// File: rtl/sdc_readback.sv
module sdc_readback
    import stream_dbg_pkg::*;
#(
    parameter int NUM_IF = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [NUM_IF-1:0][CNT_W-1:0]  valid_cnt,
    input  logic [NUM_IF-1:0][CNT_W-1:0]  frame_cnt,
    input  logic [NUM_IF-1:0][CNT_W-1:0]  pkt_cnt,
    output logic [RD_W-1:0]               rd_data
);
    localparam int IDX_W = ADDR_W - WIN_SHIFT;

    typedef struct packed {
        logic [RD_W-1:0] data;
    } rb_state_t;

    rb_state_t          st_d, st_q;
    logic [IDX_W-1:0]   idx;
    logic [7:0]         off;
    cnt_sel_e           sel;
    logic [RD_W-1:0]    picked;

    assign idx = rd_addr[ADDR_W-1:WIN_SHIFT];
    assign off = rd_addr[7:0];

    always_comb begin
        case (off)
            OFF_VALID: sel = SEL_VALID;
            OFF_FRAME: sel = SEL_FRAME;
            OFF_PKT:   sel = SEL_PKT;
            default:   sel = SEL_NONE;
        endcase
    end

    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_IF; i++) begin
            if (idx == IDX_W'(i)) begin
                case (sel)
                    SEL_VALID: picked = RD_W'(valid_cnt[i]);
                    SEL_FRAME: picked = RD_W'(frame_cnt[i]);
                    SEL_PKT:   picked = RD_W'(pkt_cnt[i]);
                    default:   picked = '0;
                endcase
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.data = picked;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;

    // R7: the result holds between reads
    a_r7_hold_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    // R6: unmapped offsets read as zero
    a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && off != OFF_VALID && off != OFF_FRAME && off != OFF_PKT)
        |=> (rd_data == '0));
endmodule

// File: rtl/stream_dbg_counters.sv
module stream_dbg_counters
    import stream_dbg_pkg::*;
#(
    parameter int NUM_IF = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IF-1:0] sif_tvalid,
    input  logic [NUM_IF-1:0] sif_tready,
    input  logic [NUM_IF-1:0] sif_tlast,
    input  logic [NUM_IF-1:0] pkt_sent,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    logic [NUM_IF-1:0][CNT_W-1:0] valid_cnt;
    logic [NUM_IF-1:0][CNT_W-1:0] frame_cnt;
    logic [NUM_IF-1:0][CNT_W-1:0] pkt_cnt;
    logic [NUM_IF-1:0]            sof;

    for (genvar g = 0; g < NUM_IF; g++) begin : g_if
        sdc_sof_tracker u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .tvalid (sif_tvalid[g]),
            .tready (sif_tready[g]),
            .tlast  (sif_tlast[g]),
            .sof_o  (sof[g])
        );

        sdc_counter #(.W(CNT_W)) u_valid (
            .clk (clk), .rst_n (rst_n), .inc (sif_tvalid[g]), .cnt_o (valid_cnt[g])
        );
        sdc_counter #(.W(CNT_W)) u_frame (
            .clk (clk), .rst_n (rst_n), .inc (sof[g]), .cnt_o (frame_cnt[g])
        );
        sdc_counter #(.W(CNT_W)) u_pkt (
            .clk (clk), .rst_n (rst_n), .inc (pkt_sent[g]), .cnt_o (pkt_cnt[g])
        );

        // R2: a frame start only happens on a completed handshake
        a_r2_start_is_hs: assert property (@(posedge clk) disable iff (!rst_n)
            sof[g] |-> (sif_tvalid[g] && sif_tready[g]));
        // R1: the frame count never outruns the valid count between edges
        a_r1_valid_moves_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
            sof[g] |=> (valid_cnt[g] != $past(valid_cnt[g])));
    end

    sdc_readback #(.NUM_IF(NUM_IF), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .valid_cnt (valid_cnt),
        .frame_cnt (frame_cnt),
        .pkt_cnt   (pkt_cnt),
        .rd_data   (rd_data)
    );

    initial begin
        a_r6_window_fits: assert (NUM_IF <= (1 << (ADDR_W - WIN_SHIFT)) && CNT_W <= RD_W);
    end
endmodule

// File: tb/stream_dbg_counters_test.sv
module stream_dbg_counters_test;
    localparam int N = 2;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  tv = '0, tr = '0, tl = '0, ps = '0;
    logic          re = 1'b0;
    logic [AW-1:0] ra = '0;
    logic [31:0]   rd, rd_w;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [31:0] m_v [N];
    logic [31:0] m_f [N];
    logic [31:0] m_p [N];
    bit          m_arm [N];

    always #10 clk = ~clk;

    stream_dbg_counters #(.NUM_IF(N), .CNT_W(32), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .sif_tvalid(tv), .sif_tready(tr), .sif_tlast(tl),
        .pkt_sent(ps), .rd_en(re), .rd_addr(ra), .rd_data(rd));

    stream_dbg_counters #(.NUM_IF(N), .CNT_W(8), .ADDR_W(AW)) uut_w (
        .clk(clk), .rst_n(rst_n), .sif_tvalid(tv), .sif_tready(tr), .sif_tlast(tl),
        .pkt_sent(ps), .rd_en(re), .rd_addr(ra), .rd_data(rd_w));

    function automatic logic [31:0] mread(logic [AW-1:0] a);
        int i = int'(a[AW-1:8]);
        if (i >= N) return 32'h0;
        case (a[7:0])
            8'h80:   return m_v[i];
            8'h84:   return m_f[i];
            8'h88:   return m_p[i];
            default: return 32'h0;
        endcase
    endfunction

    task automatic mclear();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_f[i] = 0; m_p[i] = 0; m_arm[i] = 1;
        end
    endtask

    task automatic mupdate(logic [N-1:0] v, logic [N-1:0] r, logic [N-1:0] l, logic [N-1:0] p);
        for (int i = 0; i < N; i++) begin
            if (v[i]) m_v[i] = m_v[i] + 1;
            if (p[i]) m_p[i] = m_p[i] + 1;
            if (v[i] && r[i]) begin
                if (m_arm[i]) m_f[i] = m_f[i] + 1;
                m_arm[i] = l[i];
            end
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(string req, logic [N-1:0] v, logic [N-1:0] r, logic [N-1:0] l,
                        logic [N-1:0] p, logic e, logic [AW-1:0] a);
        logic [31:0] exp;
        @(negedge clk);
        tv = v; tr = r; tl = l; ps = p; re = e; ra = a;
        exp = mread(a);
        @(posedge clk);
        mupdate(v, r, l, p);
        #2;
        if (e) begin
            chk(req, rd, exp);
            chk({req, " narrow"}, rd_w, exp & 32'hFF);
        end
    endtask

    task automatic rd_all(string req);
        for (int i = 0; i < N; i++) begin
            step(req, '0, '0, '0, '0, 1'b1, AW'(i * 256 + 'h80));
            step(req, '0, '0, '0, '0, 1'b1, AW'(i * 256 + 'h84));
            step(req, '0, '0, '0, '0, 1'b1, AW'(i * 256 + 'h88));
        end
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        mclear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state reads zero
        rd_all("R9 reset");

        // R1: valid with ready low still counts; R3: tlast without handshake ignored
        repeat (5) step("R1", 2'b01, 2'b00, 2'b01, 2'b00, 1'b0, '0);
        step("R1 valid no ready", '0, '0, '0, '0, 1'b1, 12'h080);
        step("R3 no arm", '0, '0, '0, '0, 1'b1, 12'h084);
        // R2: first handshake after reset is a frame start
        step("R2", 2'b01, 2'b01, 2'b00, 2'b00, 1'b0, '0);
        step("R2", 2'b01, 2'b01, 2'b00, 2'b00, 1'b0, '0);
        step("R2 first start", '0, '0, '0, '0, 1'b1, 12'h084);
        // R3: ready with last but no valid does not arm
        step("R3", 2'b00, 2'b01, 2'b01, 2'b00, 1'b0, '0);
        step("R3", 2'b01, 2'b01, 2'b00, 2'b00, 1'b0, '0);
        step("R3 ready-only last", '0, '0, '0, '0, 1'b1, 12'h084);
        // R2: handshake with last, then stall, then next handshake starts a frame
        step("R2", 2'b01, 2'b01, 2'b01, 2'b00, 1'b0, '0);
        step("R2", 2'b01, 2'b00, 2'b00, 2'b00, 1'b0, '0);
        step("R2", 2'b01, 2'b01, 2'b00, 2'b00, 1'b0, '0);
        step("R2 start after last", '0, '0, '0, '0, 1'b1, 12'h084);
        // R4: single-beat frames each count
        repeat (4) step("R4", 2'b01, 2'b01, 2'b01, 2'b00, 1'b0, '0);
        step("R4 single beats", '0, '0, '0, '0, 1'b1, 12'h084);
        // R5: packet pulses
        repeat (3) step("R5", 2'b00, 2'b00, 2'b00, 2'b01, 1'b0, '0);
        step("R5 packets", '0, '0, '0, '0, 1'b1, 12'h088);
        // R10: interface 1 untouched so far
        step("R10 if1 valid", '0, '0, '0, '0, 1'b1, 12'h180);
        step("R10 if1 frame", '0, '0, '0, '0, 1'b1, 12'h184);
        step("R10 if1 pkt", '0, '0, '0, '0, 1'b1, 12'h188);
        // R6: unmapped offsets and windows
        step("R6 bad offset", '0, '0, '0, '0, 1'b1, 12'h08C);
        step("R6 offset zero", '0, '0, '0, '0, 1'b1, 12'h000);
        step("R6 bad window", '0, '0, '0, '0, 1'b1, 12'h380);
        // R7: read during increment returns pre-edge value; hold while idle
        step("R7 read on inc", 2'b01, 2'b01, 2'b00, 2'b01, 1'b1, 12'h080);
        step("R7 read on inc", 2'b01, 2'b00, 2'b00, 2'b01, 1'b1, 12'h088);
        begin
            logic [31:0] held;
            held = rd;
            step("R7", 2'b11, 2'b00, 2'b00, 2'b11, 1'b0, 12'h080);
            chk("R7 hold", rd, held);
        end

        // Random phase, R8 wrap covered by narrow instance
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] v, r, l, p;
            logic e;
            logic [AW-1:0] a;
            v = N'($urandom_range(0, 3));
            if ($urandom_range(0, 3) != 0) v = v | 2'b01;
            r = N'($urandom_range(0, 3));
            l = N'($urandom_range(0, 3)) & N'($urandom_range(0, 3));
            p = N'($urandom_range(0, 3)) & N'($urandom_range(0, 3));
            e = ($urandom_range(0, 7) == 0);
            a = AW'($urandom_range(0, 2) * 256 + 'h80 + 4 * $urandom_range(0, 3));
            step("R8 random", v, r, l, p, e, a);
        end
        rd_all("R8 wrap");

        // R9: reset mid-run
        @(negedge clk);
        rst_n = 1'b0; tv = '0; tr = '0; tl = '0; ps = '0; re = 1'b0;
        repeat (2) @(negedge clk);
        mclear();
        rst_n = 1'b1;
        rd_all("R9 mid reset");
        step("R9 rearm", 2'b10, 2'b10, 2'b00, 2'b00, 1'b0, '0);
        step("R9 rearm", '0, '0, '0, '0, 1'b1, 12'h184);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule